// File: doc/BRIEF.md
# Audio Control Command Decoder

The block sits behind a serial control receiver in an audio signal path. Each received command byte arrives with a one-cycle valid strobe. The leading bits of the byte select the setting it targets, and the remaining bits are stored in that setting's latch. The prefix is variable in length: two bits for the master volume, three bits for the input switch and the four speaker attenuators, and four bits for the two tone controls.

The outputs feed the gain stages that follow. Every latch shows its raw fields. Next to the fields, the block gives each setting as a signed integer in quarter-dB units, a mute flag per speaker, and the selected stereo input as a two-bit code.

A byte that asks for one of the reserved input selections changes nothing. Instead it raises an error pulse for one cycle.

Top module: `audio_cmd_decoder`

## Requirements
- R1: A byte with bits 7..6 = 00 loads the volume latch. Bits 5..3 are the coarse field (10 dB per step) and bits 2..0 are the fine field (1.25 dB per step). vol_qdb equals -(40*coarse + 5*fine); for example, 8'h24 gives -180.
- R2: A byte with bit 7 = 1 loads the speaker attenuator whose index is bits 6..5: 0 front left, 1 front right, 2 rear left, 3 rear right. Bits 4..3 are the coarse field (10 dB per step) and bits 2..0 are the fine field. Speaker i occupies slice i of spk_coarse, spk_fine and spk_qdb, and its spk_qdb equals -(40*coarse + 5*fine); for example, 8'hB4 gives -100 on speaker 1.
- R3: spk_mute[i] is 1 exactly when speaker i holds coarse 11 and fine 111, which is the all-ones code in the low five bits.
- R4: A byte with bits 7..5 = 010 and bit 2 = 0 loads sel_code from bits 1..0 (value k selects stereo input k+1) and gain_code from bits 4..3. gain_qdb equals 25*(3 - gain_code); for example, 8'h49 gives input code 1 and gain_qdb 50.
- R5: A byte with bits 7..5 = 010 and bit 2 = 1 leaves sel_code and gain_code unchanged. It sets sel_err high for exactly the cycle after its strobe.
- R6: A byte with bits 7..4 = 0110 loads bass_code and a byte with bits 7..4 = 0111 loads treble_code, each from bits 3..0. The derived value is 8*m - 56 when bit 3 is 0, and 56 - 8*m when bit 3 is 1, where m is bits 2..0. Codes 0111 and 1111 both give 0; for example, 8'h62 gives bass_qdb -40.
- R7: A latch changes in the cycle after a valid strobe addresses it, and at no other time. A cycle without a strobe changes no output, and a strobed byte changes only the latch it addresses.
- R8: After reset the outputs are as follows. Volume coarse is 111 and fine is 111 (-315). Every speaker has coarse 11 and fine 111, so every speaker is muted. sel_code is 00 and gain_code is 11 (0). Bass and treble hold 0111. sel_err is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Strobe marking a new command byte |
| cmd_byte | input | 8 | Command byte |
| vol_coarse | output | 3 | Volume coarse field |
| vol_fine | output | 3 | Volume fine field |
| vol_qdb | output | QW | Volume in signed quarter-dB |
| spk_coarse | output | 2*NSPK | Speaker coarse fields, speaker i at bits 2i+1..2i |
| spk_fine | output | 3*NSPK | Speaker fine fields, speaker i at bits 3i+2..3i |
| spk_qdb | output | QW*NSPK | Speaker levels in signed quarter-dB, one QW slice each |
| spk_mute | output | NSPK | Per-speaker mute flags |
| sel_code | output | 2 | Selected stereo input minus one |
| gain_code | output | 2 | Input gain field |
| gain_qdb | output | QW | Input gain in signed quarter-dB |
| bass_code | output | 4 | Bass sign-magnitude code |
| treble_code | output | 4 | Treble sign-magnitude code |
| bass_qdb | output | QW | Bass in signed quarter-dB |
| treble_qdb | output | QW | Treble in signed quarter-dB |
| sel_err | output | 1 | One-cycle pulse for a reserved input selection |

## Verification
The hardest case to bring about is a reserved switch byte that arrives right after a legal switch byte, or straight after another reserved byte. Proving it requires showing that the selector keeps the older value and that the error pulse neither stretches nor is lost. The bench covers this with directed back-to-back strobes on consecutive cycles. It also uses seeded random bytes, strobed on about three cycles in four, so switch, speaker and tone commands arrive in dense runs with both legal and reserved selections. A reference model updates its state at every clock edge, and every output is compared with that model on every cycle.

// File: rtl/audio_cmd_pkg.sv
package audio_cmd_pkg;
   // Quarter-dB weights of the attenuation and gain steps
   localparam int unsigned QDB_COARSE = 40;
   localparam int unsigned QDB_FINE   = 5;
   localparam int unsigned QDB_GAIN   = 25;
   localparam int unsigned QDB_TONE   = 8;
   localparam int unsigned QDB_TONE_MAX = 56;

   typedef enum logic [2:0] {
      K_VOLUME,
      K_SPEAKER,
      K_SWITCH,
      K_BASS,
      K_TREBLE
   } cmd_kind_e;
endpackage

// File: rtl/acd_classify.sv
module acd_classify
   import audio_cmd_pkg::*;
#(
   parameter int SPK_SEL_W = 2,
   localparam int NSPK = 1 << SPK_SEL_W
) (
   input  logic            valid,
   input  logic [7:0]      byte_in,
   output logic            ld_vol,
   output logic [NSPK-1:0] ld_spk,
   output logic            ld_sw,
   output logic            ld_bass,
   output logic            ld_treble,
   output logic            bad_sel
);
   cmd_kind_e kind;

   // Variable-length prefix decode: 1xx, 00, 010, 011x
   always_comb begin
      if (byte_in[7])                 kind = K_SPEAKER;
      else if (!byte_in[6])           kind = K_VOLUME;
      else if (!byte_in[5])           kind = K_SWITCH;
      else if (!byte_in[4])           kind = K_BASS;
      else                            kind = K_TREBLE;
   end

   always_comb begin
      ld_vol    = valid && (kind == K_VOLUME);
      ld_bass   = valid && (kind == K_BASS);
      ld_treble = valid && (kind == K_TREBLE);
      // Inputs 5..8 are reserved: bit 2 set flags the byte, no load
      ld_sw     = valid && (kind == K_SWITCH) && !byte_in[2];
      bad_sel   = valid && (kind == K_SWITCH) &&  byte_in[2];
      ld_spk    = '0;
      if (valid && kind == K_SPEAKER)
         ld_spk[byte_in[7-SPK_SEL_W +: SPK_SEL_W]] = 1'b1;
   end
endmodule

// File: rtl/acd_atten_ch.sv
module acd_atten_ch
   import audio_cmd_pkg::*;
#(
   parameter int CW = 3,
   parameter int FW = 3,
   parameter int QW = 10
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 load,
   input  logic [CW-1:0]        coarse_in,
   input  logic [FW-1:0]        fine_in,
   output logic [CW-1:0]        coarse,
   output logic [FW-1:0]        fine,
   output logic signed [QW-1:0] qdb,
   output logic                 all_ones
);
   // Reset to the deepest attenuation (all-ones code)
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         coarse <= '1;
         fine   <= '1;
      end else if (load) begin
         coarse <= coarse_in;
         fine   <= fine_in;
      end
   end

   always_comb begin
      qdb      = QW'(0) - QW'(coarse) * QW'(QDB_COARSE) - QW'(fine) * QW'(QDB_FINE);
      all_ones = &{coarse, fine};
   end
endmodule

// File: rtl/acd_tone_ch.sv
module acd_tone_ch
   import audio_cmd_pkg::*;
#(
   parameter int        QW        = 10,
   parameter logic [3:0] FLAT_CODE = 4'b0111
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 load,
   input  logic [3:0]           code_in,
   output logic [3:0]           code,
   output logic signed [QW-1:0] qdb
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    code <= FLAT_CODE;
      else if (load) code <= code_in;
   end

   // Sign-magnitude: sign 0 counts up from -14 dB, sign 1 counts down from +14 dB
   always_comb begin
      if (code[3]) qdb = QW'(QDB_TONE_MAX) - QW'(code[2:0]) * QW'(QDB_TONE);
      else         qdb = QW'(code[2:0]) * QW'(QDB_TONE) - QW'(QDB_TONE_MAX);
   end
endmodule

// File: rtl/audio_cmd_decoder.sv
module audio_cmd_decoder
   import audio_cmd_pkg::*;
#(
   parameter int   QW            = 10,
   parameter int   SPK_SEL_W     = 2,
   parameter logic TONE_FLAT_POS = 1'b0,
   localparam int  NSPK          = 1 << SPK_SEL_W
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   cmd_valid,
   input  logic [7:0]             cmd_byte,
   output logic [2:0]             vol_coarse,
   output logic [2:0]             vol_fine,
   output logic signed [QW-1:0]   vol_qdb,
   output logic [2*NSPK-1:0]      spk_coarse,
   output logic [3*NSPK-1:0]      spk_fine,
   output logic [QW*NSPK-1:0]     spk_qdb,
   output logic [NSPK-1:0]        spk_mute,
   output logic [1:0]             sel_code,
   output logic [1:0]             gain_code,
   output logic signed [QW-1:0]   gain_qdb,
   output logic [3:0]             bass_code,
   output logic [3:0]             treble_code,
   output logic signed [QW-1:0]   bass_qdb,
   output logic signed [QW-1:0]   treble_qdb,
   output logic                   sel_err
);
   localparam logic [3:0] FLAT = TONE_FLAT_POS ? 4'b1111 : 4'b0111;

   // -78.75 dB needs -315 quarter-dB, which takes 10 signed bits
   if (QW < 10) begin : g_qw_check
      $error("QW must be at least 10");
   end
   if (SPK_SEL_W != 2) begin : g_spk_check
      $error("speaker index field is two bits wide");
   end

   logic            ld_vol, ld_sw, ld_bass, ld_treble, bad_sel;
   logic [NSPK-1:0] ld_spk;

   acd_classify #(.SPK_SEL_W(SPK_SEL_W)) u_cls (
      .valid     (cmd_valid),
      .byte_in   (cmd_byte),
      .ld_vol    (ld_vol),
      .ld_spk    (ld_spk),
      .ld_sw     (ld_sw),
      .ld_bass   (ld_bass),
      .ld_treble (ld_treble),
      .bad_sel   (bad_sel)
   );

   logic vol_ones;
   acd_atten_ch #(.CW(3), .FW(3), .QW(QW)) u_vol (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (ld_vol),
      .coarse_in (cmd_byte[5:3]),
      .fine_in   (cmd_byte[2:0]),
      .coarse    (vol_coarse),
      .fine      (vol_fine),
      .qdb       (vol_qdb),
      .all_ones  (vol_ones)
   );

   for (genvar i = 0; i < NSPK; i++) begin : g_spk
      logic signed [QW-1:0] q;
      acd_atten_ch #(.CW(2), .FW(3), .QW(QW)) u_att (
         .clk       (clk),
         .rst_n     (rst_n),
         .load      (ld_spk[i]),
         .coarse_in (cmd_byte[4:3]),
         .fine_in   (cmd_byte[2:0]),
         .coarse    (spk_coarse[2*i +: 2]),
         .fine      (spk_fine[3*i +: 3]),
         .qdb       (q),
         .all_ones  (spk_mute[i])
      );
      assign spk_qdb[QW*i +: QW] = q;
   end

   // Input switch latches and error pulse
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_code  <= 2'b00;
         gain_code <= 2'b11;
         sel_err   <= 1'b0;
      end else begin
         sel_err <= bad_sel;
         if (ld_sw) begin
            sel_code  <= cmd_byte[1:0];
            gain_code <= cmd_byte[4:3];
         end
      end
   end

   assign gain_qdb = QW'(QDB_GAIN) * QW'(2'd3 - gain_code);

   acd_tone_ch #(.QW(QW), .FLAT_CODE(FLAT)) u_bass (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (ld_bass),
      .code_in (cmd_byte[3:0]),
      .code    (bass_code),
      .qdb     (bass_qdb)
   );

   acd_tone_ch #(.QW(QW), .FLAT_CODE(FLAT)) u_treble (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (ld_treble),
      .code_in (cmd_byte[3:0]),
      .code    (treble_code),
      .qdb     (treble_qdb)
   );

   logic unused_ok;
   assign unused_ok = vol_ones;
endmodule

// File: rtl/acd_checker.sv
module acd_checker #(
   parameter int QW   = 10,
   parameter int NSPK = 4
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 cmd_valid,
   input logic [7:0]           cmd_byte,
   input logic [2:0]           vol_coarse,
   input logic [2:0]           vol_fine,
   input logic signed [QW-1:0] vol_qdb,
   input logic [2*NSPK-1:0]    spk_coarse,
   input logic [1:0]           sel_code,
   input logic [1:0]           gain_code,
   input logic [3:0]           bass_code,
   input logic [3:0]           treble_code,
   input logic signed [QW-1:0] bass_qdb,
   input logic                 sel_err
);
   p_vol_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_byte[7:6] == 2'b00) |=>
         (vol_coarse == $past(cmd_byte[5:3]) && vol_fine == $past(cmd_byte[2:0])));

   p_vol_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (vol_qdb <= 0) && (vol_qdb >= -315));

   p_spk_rf_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_byte[7:5] == 3'b101) |=> (spk_coarse[3:2] == $past(cmd_byte[4:3])));

   p_bad_sel_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_byte[7:5] == 3'b010 && cmd_byte[2]) |=>
         (sel_err && $stable(sel_code) && $stable(gain_code)));

   p_err_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
      sel_err |-> $past(cmd_valid));

   p_tone_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (bass_qdb >= -56) && (bass_qdb <= 56) && (bass_qdb[2:0] == 3'b000));

   p_idle_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !cmd_valid |=> ($stable(vol_coarse) && $stable(vol_fine) && $stable(spk_coarse)
                      && $stable(sel_code) && $stable(bass_code) && $stable(treble_code)
                      && !sel_err));
endmodule

bind audio_cmd_decoder acd_checker #(.QW(QW), .NSPK(NSPK)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .cmd_valid   (cmd_valid),
   .cmd_byte    (cmd_byte),
   .vol_coarse  (vol_coarse),
   .vol_fine    (vol_fine),
   .vol_qdb     (vol_qdb),
   .spk_coarse  (spk_coarse),
   .sel_code    (sel_code),
   .gain_code   (gain_code),
   .bass_code   (bass_code),
   .treble_code (treble_code),
   .bass_qdb    (bass_qdb),
   .sel_err     (sel_err)
);

// File: tb/audio_cmd_decoder_test.sv
module audio_cmd_decoder_test;
   localparam int QW = 10;
   localparam int NS = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cmd_valid = 1'b0;
   logic [7:0] cmd_byte = 8'h00;
   logic [2:0] vol_coarse, vol_fine;
   logic signed [QW-1:0] vol_qdb, gain_qdb, bass_qdb, treble_qdb;
   logic [2*NS-1:0] spk_coarse;
   logic [3*NS-1:0] spk_fine;
   logic [QW*NS-1:0] spk_qdb;
   logic [NS-1:0] spk_mute;
   logic [1:0] sel_code, gain_code;
   logic [3:0] bass_code, treble_code;
   logic sel_err;

   always #2 clk = ~clk;

   audio_cmd_decoder uut (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_byte(cmd_byte),
      .vol_coarse(vol_coarse), .vol_fine(vol_fine), .vol_qdb(vol_qdb),
      .spk_coarse(spk_coarse), .spk_fine(spk_fine), .spk_qdb(spk_qdb),
      .spk_mute(spk_mute), .sel_code(sel_code), .gain_code(gain_code),
      .gain_qdb(gain_qdb), .bass_code(bass_code), .treble_code(treble_code),
      .bass_qdb(bass_qdb), .treble_qdb(treble_qdb), .sel_err(sel_err)
   );

   int n_run = 0, n_fail = 0;
   bit done = 1'b0;

   // Reference state
   int e_vc = 7, e_vf = 7, e_sel = 0, e_gain = 3, e_bass = 7, e_treb = 7, e_err = 0;
   int e_sc[NS] = '{3, 3, 3, 3};
   int e_sf[NS] = '{7, 7, 7, 7};

   function automatic int att_q(int c, int f);
      return -(40 * c + 5 * f);
   endfunction
   function automatic int tone_q(int code);
      if (code >= 8) return 56 - 8 * (code - 8);
      return 8 * code - 56;
   endfunction

   task automatic chk(input string tag, input int act, input int exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic check_all(input string ctx);
      chk({ctx, " R1 vol_coarse"}, int'(vol_coarse), e_vc);
      chk({ctx, " R1 vol_fine"}, int'(vol_fine), e_vf);
      chk({ctx, " R1 vol_qdb"}, int'(vol_qdb), att_q(e_vc, e_vf));
      for (int i = 0; i < NS; i++) begin
         chk({ctx, " R2 spk_coarse"}, int'(spk_coarse[2*i +: 2]), e_sc[i]);
         chk({ctx, " R2 spk_fine"}, int'(spk_fine[3*i +: 3]), e_sf[i]);
         chk({ctx, " R2 spk_qdb"}, int'($signed(spk_qdb[QW*i +: QW])), att_q(e_sc[i], e_sf[i]));
         chk({ctx, " R3 spk_mute"}, int'(spk_mute[i]), (e_sc[i] == 3 && e_sf[i] == 7) ? 1 : 0);
      end
      chk({ctx, " R4 sel_code"}, int'(sel_code), e_sel);
      chk({ctx, " R4 gain_code"}, int'(gain_code), e_gain);
      chk({ctx, " R4 gain_qdb"}, int'(gain_qdb), 25 * (3 - e_gain));
      chk({ctx, " R5 sel_err"}, int'(sel_err), e_err);
      chk({ctx, " R6 bass_code"}, int'(bass_code), e_bass);
      chk({ctx, " R6 treble_code"}, int'(treble_code), e_treb);
      chk({ctx, " R6 bass_qdb"}, int'(bass_qdb), tone_q(e_bass));
      chk({ctx, " R6 treble_qdb"}, int'(treble_qdb), tone_q(e_treb));
   endtask

   // One cycle: drive at negedge, model at posedge, compare at next negedge (R7 timing)
   task automatic cyc(input bit v, input logic [7:0] b, input string ctx);
      cmd_valid = v;
      cmd_byte  = b;
      @(posedge clk);
      e_err = 0;
      if (v) begin
         if (b[7]) begin
            e_sc[b[6:5]] = int'(b[4:3]);
            e_sf[b[6:5]] = int'(b[2:0]);
         end else if (!b[6]) begin
            e_vc = int'(b[5:3]);
            e_vf = int'(b[2:0]);
         end else if (!b[5]) begin
            if (b[2]) e_err = 1;
            else begin
               e_sel  = int'(b[1:0]);
               e_gain = int'(b[4:3]);
            end
         end else if (!b[4]) e_bass = int'(b[3:0]);
         else                e_treb = int'(b[3:0]);
      end
      @(negedge clk);
      check_all(ctx);
   endtask

   initial begin
      #(200000 * 4);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      int seed;
      seed = $urandom(32'h5eed_acd1);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      check_all("reset R8");
      chk("R8 all muted", int'(spk_mute), 15);
      chk("R8 volume floor", int'(vol_qdb), -315);

      // R9-style worked values
      cyc(1'b1, 8'h24, "example");
      chk("R1 -45 dB", int'(vol_qdb), -180);
      cyc(1'b1, 8'hB4, "example");
      chk("R2 front right -25 dB", int'($signed(spk_qdb[QW +: QW])), -100);
      cyc(1'b1, 8'h49, "example");
      chk("R4 input 2 gain", int'(gain_qdb), 50);
      cyc(1'b1, 8'h62, "example");
      chk("R6 bass -10 dB", int'(bass_qdb), -40);

      // R6: both flat codes
      cyc(1'b1, 8'h7F, "tone flat");
      chk("R6 treble 1111 flat", int'(treble_qdb), 0);
      cyc(1'b1, 8'h77, "tone flat");
      chk("R6 treble 0111 flat", int'(treble_qdb), 0);
      cyc(1'b1, 8'h68, "tone max");
      chk("R6 bass +14 dB", int'(bass_qdb), 56);

      // R3: mute on rear right, then unmute by one step
      cyc(1'b1, 8'hFF, "mute");
      chk("R3 rear right muted", int'(spk_mute[3]), 1);
      cyc(1'b1, 8'hFE, "mute");
      chk("R3 rear right unmuted", int'(spk_mute[3]), 0);

      // R5: reserved right after legal, then twice in a row, then idle
      cyc(1'b1, 8'h52, "switch");
      cyc(1'b1, 8'h4C, "reserved");
      chk("R5 err pulse", int'(sel_err), 1);
      chk("R5 sel kept", int'(sel_code), 2);
      cyc(1'b1, 8'h5F, "reserved");
      cyc(1'b1, 8'h44, "reserved");
      cyc(1'b0, 8'h44, "R7 idle");
      chk("R5 pulse ends", int'(sel_err), 0);

      // R7: idle with a byte on the bus changes nothing
      for (int k = 0; k < 8; k++) cyc(1'b0, 8'(k * 37), "R7 idle");

      // Random mix
      for (int k = 0; k < 4000; k++)
         cyc(($urandom % 4) != 0, 8'($urandom), "random");

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule